// File: doc/BRIEF.md
# Edge-Driven Event Counter with Buffered Compare

The block counts edges on an external event line. The line is sampled on the block clock and passes through a short synchronizer. Software picks whether rising or falling transitions count. A 16-bit counter advances once for each selected transition. When the count equals the active compare value and one more event arrives, the counter returns to zero, a one-cycle interrupt pulse is raised and the timer output toggles. So the interrupt period is compare + 1 events.

The compare value can be written straight into the active register, which is direct mode. It can also be written into a shadow buffer that moves into the active register only when the counter clears on a match or when an initialize is issued, which is buffered mode. Buffered mode lets software change the period while counting without cutting the current cycle short. Clearing the run bit freezes the counter, the compare value and the output, so counting resumes exactly where it stopped.

Top module: `evtc_top`

## Requirements
- R1: After reset, `count_out` is 0 and `irq` and `tmr_out` are low.
- R2: With run set and rising edge selected (`edge_fall` = 0 in the control register), each low-to-high change of `evt_pin` adds one to the count. A level present at clock edge k (and absent at edge k-1) changes `count_out` at edge k+2. Falling changes do not count.
- R3: With `edge_fall` = 1, only high-to-low changes of `evt_pin` count, with the same two-cycle latency as R2.
- R4: When a selected edge arrives while the count equals the active compare value, the count becomes 0. `irq` is high for exactly the one cycle in which `count_out` first reads 0. The period is compare + 1 events.
- R5: `tmr_out` inverts on every compare-match clear.
- R6: In direct mode (`dbuf` = 0), a compare write takes effect at the next edge. If the new value is below the current count, the counter keeps counting, rolls from 0xFFFF to 0 without `irq` or a `tmr_out` change, and later matches.
- R7: In buffered mode (`dbuf` = 1), a compare write changes only the buffer. The buffer moves into the active compare value at the next match clear, so the current period completes with the old value.
- R8: While run is 0, `count_out`, `tmr_out` and the active compare value hold, and events are ignored. Setting run again resumes from the held count.
- R9: A control write with `ctl_load` = 1 clears the count and drives `tmr_out` low at that edge, without an `irq`. If that write selects buffered mode, it also copies the buffer into the active compare value.
- R10: A pulse on `evt_pin` that begins and ends between two rising clock edges is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also samples the event line |
| rst | input | 1 | Synchronous active-high reset |
| cmp_we | input | 1 | Compare write strobe |
| cmp_wdata | input | 16 | Compare value to write |
| ctl_we | input | 1 | Control write strobe |
| ctl_run | input | 1 | Count enable |
| ctl_edge_fall | input | 1 | 0 counts rising edges, 1 counts falling edges |
| ctl_dbuf | input | 1 | 1 selects buffered compare mode |
| ctl_load | input | 1 | Initialize request, acts only during a control write |
| evt_pin | input | 1 | External event line |
| count_out | output | 16 | Current counter value |
| tmr_out | output | 1 | Toggling timer output |
| irq | output | 1 | One-cycle compare interrupt pulse |

## Verification
On every cycle, the assertions check the following:
- the count strobe never lasts two cycles;
- an interrupt only coincides with a zero count and a flipped timer output;
- a stopped counter does not move;
- an initialize always leaves zero and a low output;
- a direct write lands in the active compare value;
- in buffered mode, the active value stays fixed between transfers.

Only the bench scenarios can show the following:
- the end-to-end period in events;
- that a buffered change waits for the current period to finish;
- the silent 16-bit rollover after a direct write below the count;
- that resuming after a stop continues from the held count;
- that a sub-cycle glitch is missed.

// File: rtl/evtc_pkg.sv
`timescale 1ns/1ps
package evtc_pkg;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sel_e;

    typedef struct packed {
        logic      run;
        edge_sel_e edge_sel;
        logic      dbuf;
    } evtc_ctrl_t;

    // True when the synchronized samples form the selected transition
    function automatic logic edge_hit(edge_sel_e sel, logic cur, logic prev);
        if (sel == EDGE_FALL) return (!cur && prev);
        return (cur && !prev);
    endfunction

endpackage

// File: rtl/evtc_ctrl_reg.sv
`timescale 1ns/1ps
module evtc_ctrl_reg
    import evtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_we,
    input  evtc_ctrl_t ctl_wdata,
    input  logic       ctl_load,
    output evtc_ctrl_t ctrl_q,
    output logic       init_pulse,
    output logic       init_dbuf
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{run: 1'b0, edge_sel: EDGE_RISE, dbuf: 1'b0};
        end else if (ctl_we) begin
            ctrl_q <= ctl_wdata;
        end
    end

    // Initialize acts in the same edge as the control write
    assign init_pulse = ctl_we && ctl_load;
    assign init_dbuf  = ctl_wdata.dbuf;

endmodule

// File: rtl/evtc_edge_detect.sv
`timescale 1ns/1ps
module evtc_edge_detect
    import evtc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin,
    input  edge_sel_e sel,
    output logic      strobe
);

    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[PIPE_W-2:0], pin};
    end

    assign strobe = edge_hit(sel, pipe_q[SYNC_STAGES-1], pipe_q[SYNC_STAGES]);

    // R2: one transition yields a single-cycle strobe
    a_r2_strobe_single: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);

endmodule

// File: rtl/evtc_cmp_reg.sv
`timescale 1ns/1ps
module evtc_cmp_reg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             dbuf,
    input  logic             init,
    input  logic             init_dbuf,
    input  logic             wrap,
    output logic [CNT_W-1:0] active
);

    logic [CNT_W-1:0] shadow_q;
    logic [CNT_W-1:0] active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '1;
            active_q <= '1;
        end else begin
            if (cmp_we) shadow_q <= cmp_wdata;
            if (init && init_dbuf)   active_q <= shadow_q;
            else if (wrap && dbuf)   active_q <= shadow_q;
            else if (cmp_we && !dbuf) active_q <= cmp_wdata;
        end
    end

    assign active = active_q;

    // R6: a direct-mode write reaches the active compare value at once
    a_r6_direct_write: assert property (@(posedge clk) disable iff (rst)
        (cmp_we && !dbuf && !(init && init_dbuf)) |=> active == $past(cmp_wdata));

    // R7: in buffered mode the active value moves only on clear or initialize
    a_r7_buffer_hold: assert property (@(posedge clk) disable iff (rst)
        (dbuf && !wrap && !(init && init_dbuf)) |=> $stable(active));

endmodule

// File: rtl/evtc_count_core.sv
`timescale 1ns/1ps
module evtc_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             strobe,
    input  logic             init,
    input  logic [CNT_W-1:0] active,
    output logic [CNT_W-1:0] count,
    output logic             wrap,
    output logic             tout,
    output logic             irq
);

    logic [CNT_W-1:0] count_q;
    logic             tout_q;
    logic             irq_q;
    logic             step;
    logic             match;

    assign step  = run && strobe;
    assign match = step && (count_q == active);
    assign wrap  = match && !init;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            tout_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (init) begin
                count_q <= '0;
                tout_q  <= 1'b0;
            end else if (match) begin
                count_q <= '0;
                tout_q  <= ~tout_q;
                irq_q   <= 1'b1;
            end else if (step) begin
                count_q <= count_q + 1'b1;
            end
        end
    end

    assign count = count_q;
    assign tout  = tout_q;
    assign irq   = irq_q;

    // R4: the interrupt lasts one cycle and coincides with a zero count
    a_r4_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
    a_r4_irq_zero: assert property (@(posedge clk) disable iff (rst)
        irq |-> count_q == '0);

    // R5: every match clear flips the timer output
    a_r5_tout_flip: assert property (@(posedge clk) disable iff (rst)
        irq |-> tout_q != $past(tout_q));

    // R8: a stopped counter holds its value
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (!run && !init) |=> $stable(count_q) && $stable(tout_q));

    // R9: initialize leaves zero count and low output, no interrupt
    a_r9_init: assert property (@(posedge clk) disable iff (rst)
        init |=> (count_q == '0) && !tout_q && !irq_q);

endmodule

// File: rtl/evtc_top.sv
`timescale 1ns/1ps
module evtc_top
    import evtc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             ctl_we,
    input  logic             ctl_run,
    input  logic             ctl_edge_fall,
    input  logic             ctl_dbuf,
    input  logic             ctl_load,
    input  logic             evt_pin,
    output logic [CNT_W-1:0] count_out,
    output logic             tmr_out,
    output logic             irq
);

    evtc_ctrl_t       ctl_wdata;
    evtc_ctrl_t       ctrl_q;
    logic             init_pulse;
    logic             init_dbuf;
    logic             strobe;
    logic             wrap;
    logic [CNT_W-1:0] active;

    assign ctl_wdata = '{run: ctl_run, edge_sel: edge_sel_e'(ctl_edge_fall), dbuf: ctl_dbuf};

    evtc_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ctl_we     (ctl_we),
        .ctl_wdata  (ctl_wdata),
        .ctl_load   (ctl_load),
        .ctrl_q     (ctrl_q),
        .init_pulse (init_pulse),
        .init_dbuf  (init_dbuf)
    );

    evtc_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .pin    (evt_pin),
        .sel    (ctrl_q.edge_sel),
        .strobe (strobe)
    );

    evtc_cmp_reg #(.CNT_W(CNT_W)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .cmp_we    (cmp_we),
        .cmp_wdata (cmp_wdata),
        .dbuf      (ctrl_q.dbuf),
        .init      (init_pulse),
        .init_dbuf (init_dbuf),
        .wrap      (wrap),
        .active    (active)
    );

    evtc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk    (clk),
        .rst    (rst),
        .run    (ctrl_q.run),
        .strobe (strobe),
        .init   (init_pulse),
        .active (active),
        .count  (count_out),
        .wrap   (wrap),
        .tout   (tmr_out),
        .irq    (irq)
    );

endmodule

// File: tb/sim_evtc_top.sv
`timescale 1ns/1ps
module sim_evtc_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmp_we, ctl_we, ctl_run, ctl_edge_fall, ctl_dbuf, ctl_load, evt_pin;
    logic [15:0] cmp_wdata;
    logic [15:0] count_out;
    logic        tmr_out, irq;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;
    string cur_req = "R1";

    // reference state
    int m_cnt, m_act, m_buf, m_tout, m_irq, m_run, m_fall, m_dbuf;
    int h1, h2, h3;

    always #2.5 clk = ~clk;

    evtc_top u0 (
        .clk(clk), .rst(rst), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
        .ctl_we(ctl_we), .ctl_run(ctl_run), .ctl_edge_fall(ctl_edge_fall),
        .ctl_dbuf(ctl_dbuf), .ctl_load(ctl_load), .evt_pin(evt_pin),
        .count_out(count_out), .tmr_out(tmr_out), .irq(irq)
    );

    // Behavioural reference: a pin level seen at edge k is acted on at edge k+2
    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_act = 65535; m_buf = 65535; m_tout = 0; m_irq = 0;
            m_run = 0; m_fall = 0; m_dbuf = 0; h1 = 0; h2 = 0; h3 = 0;
        end else begin
            bit hit, init;
            int old_buf;
            hit = (m_run != 0) && (m_fall != 0 ? (h2 == 0 && h3 == 1) : (h2 == 1 && h3 == 0));
            init = ctl_we && ctl_load;
            old_buf = m_buf;
            m_irq = 0;
            if (init) begin
                m_cnt = 0; m_tout = 0;
                if (ctl_dbuf) m_act = old_buf;
            end else if (hit) begin
                if (m_cnt == m_act) begin
                    m_cnt = 0; m_tout = 1 - m_tout; m_irq = 1;
                    if (m_dbuf != 0) m_act = old_buf;
                end else begin
                    m_cnt = (m_cnt + 1) % 65536;
                end
            end
            if (cmp_we) begin
                m_buf = cmp_wdata;
                if (m_dbuf == 0 && !(init && ctl_dbuf)) m_act = cmp_wdata;
            end
            if (ctl_we) begin
                m_run = ctl_run; m_fall = ctl_edge_fall; m_dbuf = ctl_dbuf;
            end
            h3 = h2; h2 = h1; h1 = evt_pin;
        end
    end

    // Cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (count_out != m_cnt || irq != m_irq || tmr_out != m_tout) begin
                errors++;
                $display("FAIL %s model: actual cnt=%0d irq=%0d out=%0d expected cnt=%0d irq=%0d out=%0d",
                         cur_req, count_out, irq, tmr_out, m_cnt, m_irq, m_tout);
            end
            if (irq) irq_seen++;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_ctl(bit run, bit fall, bit dbuf, bit load);
        @(negedge clk);
        ctl_we = 1; ctl_run = run; ctl_edge_fall = fall; ctl_dbuf = dbuf; ctl_load = load;
        @(negedge clk);
        ctl_we = 0; ctl_load = 0;
    endtask

    task automatic wr_cmp(int v);
        @(negedge clk);
        cmp_we = 1; cmp_wdata = v[15:0];
        @(negedge clk);
        cmp_we = 0;
    endtask

    task automatic pulses(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); evt_pin = 1;
            @(negedge clk); evt_pin = 0;
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int base;
        rst = 1; cmp_we = 0; cmp_wdata = 0; ctl_we = 0; ctl_run = 0;
        ctl_edge_fall = 0; ctl_dbuf = 0; ctl_load = 0; evt_pin = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1 count", count_out, 0);
        chk("R1 irq", irq, 0);
        chk("R1 tmr_out", tmr_out, 0);

        // R2: rising edges, direct compare 4
        cur_req = "R2";
        wr_cmp(4);
        wr_ctl(1, 0, 0, 1);
        pulses(3); settle();
        chk("R2 three rising edges", count_out, 3);

        // R4 / R5: period of compare+1 events
        cur_req = "R4";
        base = irq_seen;
        pulses(1); settle();
        chk("R4 at compare no irq", irq_seen - base, 0);
        pulses(1); settle();
        chk("R4 wrap count", count_out, 0);
        chk("R4 one irq", irq_seen - base, 1);
        chk("R5 output toggled high", tmr_out, 1);
        pulses(5); settle();
        chk("R4 second period irq", irq_seen - base, 2);
        chk("R5 output toggled low", tmr_out, 0);

        // R3: falling edges
        cur_req = "R3";
        wr_ctl(1, 1, 0, 1);
        pulses(2); settle();
        chk("R3 two falling edges", count_out, 2);

        // R8: stop holds, resume continues
        cur_req = "R8";
        wr_ctl(0, 1, 0, 0);
        pulses(3); settle();
        chk("R8 held while stopped", count_out, 2);
        wr_ctl(1, 1, 0, 0);
        pulses(1); settle();
        chk("R8 resumed from held value", count_out, 3);

        // R9: initialize clears count and output, no irq
        cur_req = "R9";
        wr_ctl(1, 0, 0, 1);
        pulses(5); pulses(2); settle();
        chk("R9 pre-init count", count_out, 2);
        chk("R9 pre-init output", tmr_out, 1);
        base = irq_seen;
        wr_ctl(1, 0, 0, 1);
        settle();
        chk("R9 init count", count_out, 0);
        chk("R9 init output", tmr_out, 0);
        chk("R9 init no irq", irq_seen - base, 0);

        // R7: buffered compare change waits for the period to end
        cur_req = "R7";
        wr_ctl(1, 0, 1, 1);
        pulses(2); settle();
        wr_cmp(1);
        base = irq_seen;
        pulses(2); settle();
        chk("R7 old compare still active", count_out, 4);
        chk("R7 no early irq", irq_seen - base, 0);
        pulses(1); settle();
        chk("R7 wrap on old value", irq_seen - base, 1);
        pulses(2); settle();
        chk("R7 new period of two", irq_seen - base, 2);
        chk("R7 count after new period", count_out, 0);

        // R9: initialize in buffered mode transfers the buffer
        cur_req = "R9";
        wr_cmp(3);
        wr_ctl(1, 0, 1, 1);
        base = irq_seen;
        pulses(3); settle();
        chk("R9 transferred compare count", count_out, 3);
        pulses(1); settle();
        chk("R9 transferred compare wrap", irq_seen - base, 1);

        // R10: glitch between clock edges is missed
        cur_req = "R10";
        @(posedge clk); #1 evt_pin = 1; #1 evt_pin = 0;
        settle();
        chk("R10 glitch ignored", count_out, 0);

        // R6: direct write below current count rolls over silently
        cur_req = "R6";
        wr_ctl(1, 0, 0, 1);
        wr_cmp(100);
        pulses(5); settle();
        chk("R6 count before write", count_out, 5);
        wr_cmp(2);
        base = irq_seen;
        pulses(65531); settle();
        chk("R6 rollover count", count_out, 0);
        chk("R6 rollover no irq", irq_seen - base, 0);
        chk("R6 rollover output unchanged", tmr_out, 0);
        pulses(2); settle();
        chk("R6 count after rollover", count_out, 2);
        pulses(1); settle();
        chk("R6 match after rollover", irq_seen - base, 1);

        finish_run();
    end

endmodule